// File: doc/BRIEF.md
# Decode-Stage Direct Branch Target Verifier

This block sits in the decode slot of an instruction pipeline. Each cycle it receives a group of up to `W` instructions in program order. For every instruction it knows the PC, the PC that the fetch predictor chose to follow it, the target computed by the decoder, the control-class flags, a sequence number and a thread id. Only direct unconditional transfers are checked. When the computed target disagrees with the predicted next PC, the block stops forwarding the rest of the group. It marks younger instructions of the same thread as killed. One cycle later it presents a registered redirect record that sends fetch to the correct target.

A build-time switch selects delay-slot behaviour. Without delay slots, a mispredicted branch is forwarded and squashes at once. With delay slots, the squash normally waits until the following instruction of the same thread has been forwarded, and this wait may carry into a later cycle. The exception is a branch that was predicted taken and has a conditional delay slot: it squashes at once, and its delay-slot instruction is dropped. The block also counts checked and mispredicted branches, reports an instruction that was predicted taken but is not a control transfer, and flags instructions with no source operands as ready to issue.

Top module: `bv_top`

## Requirements
- R1: An instruction is checked only if it is forwarded and has all three flags set: control, direct and unconditional. Each checked instruction increments `resolved_cnt_o` by one. The counter is visible the cycle after.
- R2: A checked instruction whose `in_tgt` differs from `in_pred_npc` is a mispredict. Each mispredict increments `mispred_cnt_o` by one, also visible the cycle after.
- R3: A squash in cycle N makes `redir_valid_o` high for cycle N+1 only. In that cycle the record holds the branch's thread and sequence number, `redir_npc_o` = target and `redir_nnpc_o` = target + 4. The mispredict, prediction-wrong and squash flags are all set.
- R4: `redir_taken_o` is 1 exactly when the branch's predicted next PC is not its PC + 4.
- R5: With `DELAY_SLOT`=0, a mispredicted branch is forwarded and `stop_o` is raised. No later slot of the group is forwarded. A later slot is flagged in `kill_o` when it has the same thread and a sequence number above the branch's. The squash boundary equals the branch's sequence number.
- R6: With `DELAY_SLOT`=1, a mispredict whose `in_pred_taken` and `in_cond_ds` are both 1 squashes immediately, as in R5. Its boundary is its own sequence number.
- R7: With `DELAY_SLOT`=1, any other mispredict does not stop the group. The squash fires when the next instruction of the same thread is forwarded, in the same cycle or a later one. That instruction is forwarded, then `stop_o` rises, and the boundary is the branch's sequence number + 1. The record carries the branch's sequence number and target.
- R8: The instruction that fires a deferred squash is not itself checked. It changes neither counter, even if it is a mispredicting branch.
- R9: An instruction with `in_pred_taken`=1 and `in_ctrl`=0 raises `fatal_o`. It is forwarded and `stop_o` rises. No slot is killed and no redirect follows.
- R10: `ready_o[i]` = `in_valid[i]` AND `in_no_src[i]`.
- R11: After reset, `redir_valid_o` is 0, both counters are 0 and no deferred squash is pending.
- R12: Slots are scanned from index 0 upward, and invalid slots are skipped. After a stop, a slot is never forwarded, and a slot of another thread is never killed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | W | Slot holds an instruction |
| in_pc | input | W*PC_W | Instruction PC |
| in_pred_npc | input | W*PC_W | Predicted next PC |
| in_tgt | input | W*PC_W | Target computed by the decoder |
| in_ctrl | input | W | Control transfer |
| in_direct | input | W | Direct (PC-relative) transfer |
| in_uncond | input | W | Unconditional transfer |
| in_pred_taken | input | W | Predictor said taken |
| in_cond_ds | input | W | Delay slot is conditional |
| in_no_src | input | W | Instruction has no source operands |
| in_seq | input | W*SEQ_W | Sequence number |
| in_tid | input | W*TID_W | Thread id |
| fwd_o | output | W | Slot forwarded this cycle |
| kill_o | output | W | Slot squashed this cycle |
| ready_o | output | W | Slot ready to issue |
| stop_o | output | 1 | Decoding stopped within this group |
| fatal_o | output | 1 | Predicted-taken non-control instruction seen |
| redir_valid_o | output | 1 | Redirect record valid |
| redir_mispred_o | output | 1 | Branch mispredict flag |
| redir_pred_wrong_o | output | 1 | Prediction incorrect flag |
| redir_squash_o | output | 1 | Squash flag |
| redir_tid_o | output | TID_W | Thread of the redirect |
| redir_seq_o | output | SEQ_W | Sequence number of the branch |
| redir_bound_o | output | SEQ_W | Squash boundary (younger than this dies) |
| redir_npc_o | output | PC_W | Corrected next PC |
| redir_nnpc_o | output | PC_W | Corrected next-next PC |
| redir_taken_o | output | 1 | Branch taken flag |
| resolved_cnt_o | output | CNT_W | Checked branches |
| mispred_cnt_o | output | CNT_W | Mispredicted branches |

## Verification
Forward, kill, stop, fatal and ready are combinational and due in the same cycle as the input group. The bench drives each group on the falling edge and compares these outputs a short delay later, before the next rising edge. The redirect record and both counters are registered and due one cycle later. The reference model holds its expected values for them and compares them at the next falling edge. Deferred squashes in delay-slot mode may fire several cycles after the branch, so the model keeps per-thread pending state. Both a non-delay-slot instance and a delay-slot instance are checked against it on every cycle.

// File: rtl/bv_pkg.sv
`timescale 1ns/1ps
package bv_pkg;
    localparam int PC_W  = 32;
    localparam int SEQ_W = 16;
    localparam int TID_W = 1;
    localparam int NT    = 1 << TID_W;
    localparam int ILEN  = 4;

    typedef struct packed {
        logic             valid;
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  pred_npc;
        logic [PC_W-1:0]  tgt;
        logic             ctrl;
        logic             direct;
        logic             uncond;
        logic             pred_taken;
        logic             cond_ds;
        logic [SEQ_W-1:0] seq;
        logic [TID_W-1:0] tid;
    } slot_t;

    typedef struct packed {
        logic [TID_W-1:0] tid;
        logic [SEQ_W-1:0] seq;
        logic [SEQ_W-1:0] bound;
        logic [PC_W-1:0]  tgt;
        logic             taken;
    } redir_t;

    typedef enum logic [2:0] {
        SC_IDLE,
        SC_PLAIN,
        SC_HIT,
        SC_MISS_NOW,
        SC_MISS_DEFER,
        SC_FATAL
    } slot_cls_e;

    function automatic logic [PC_W-1:0] fallthru(input logic [PC_W-1:0] pc);
        return pc + PC_W'(ILEN);
    endfunction
endpackage

// File: rtl/bv_slot_class.sv
`timescale 1ns/1ps
module bv_slot_class
    import bv_pkg::*;
#(
    parameter bit DELAY_SLOT = 1'b0
) (
    input  slot_t     s,
    output slot_cls_e cls,
    output logic      taken
);
    logic checked;
    logic miss;

    assign checked = s.ctrl & s.direct & s.uncond;
    assign miss    = s.tgt != s.pred_npc;
    assign taken   = s.pred_npc != fallthru(s.pc);

    always_comb begin
        if (!s.valid) begin
            cls = SC_IDLE;
        end else if (s.pred_taken && !s.ctrl) begin
            cls = SC_FATAL;
        end else if (!checked) begin
            cls = SC_PLAIN;
        end else if (!miss) begin
            cls = SC_HIT;
        end else if (!DELAY_SLOT || (s.pred_taken && s.cond_ds)) begin
            cls = SC_MISS_NOW;
        end else begin
            cls = SC_MISS_DEFER;
        end
    end
endmodule

// File: rtl/bv_scan.sv
`timescale 1ns/1ps
module bv_scan
    import bv_pkg::*;
#(
    parameter int W  = 4,
    parameter int IW = $clog2(W + 1)
) (
    input  slot_t     [W-1:0]  slots,
    input  slot_cls_e [W-1:0]  cls,
    input  logic      [W-1:0]  taken,
    input  logic      [NT-1:0] pend_q,
    input  redir_t    [NT-1:0] prec_q,
    output logic      [W-1:0]  fwd,
    output logic      [W-1:0]  kill,
    output logic               stop,
    output logic               fatal,
    output logic      [IW-1:0] res_inc,
    output logic      [IW-1:0] mis_inc,
    output logic               ev_valid,
    output redir_t             ev_rec,
    output logic      [NT-1:0] pend_d,
    output redir_t    [NT-1:0] prec_d
);
    always_comb begin
        fwd      = '0;
        kill     = '0;
        stop     = 1'b0;
        fatal    = 1'b0;
        res_inc  = '0;
        mis_inc  = '0;
        ev_valid = 1'b0;
        ev_rec   = '0;
        pend_d   = pend_q;
        prec_d   = prec_q;
        for (int i = 0; i < W; i++) begin
            if (cls[i] != SC_IDLE) begin
                if (stop) begin
                    if (ev_valid && slots[i].tid == ev_rec.tid &&
                        slots[i].seq > ev_rec.bound) begin
                        kill[i] = 1'b1;
                    end
                end else begin
                    fwd[i] = 1'b1;
                    if (pend_d[slots[i].tid]) begin
                        ev_valid = 1'b1;
                        ev_rec   = prec_d[slots[i].tid];
                        pend_d[slots[i].tid] = 1'b0;
                        stop     = 1'b1;
                    end else begin
                        case (cls[i])
                            SC_FATAL: begin
                                fatal = 1'b1;
                                stop  = 1'b1;
                            end
                            SC_HIT: begin
                                res_inc = res_inc + IW'(1);
                            end
                            SC_MISS_NOW: begin
                                res_inc      = res_inc + IW'(1);
                                mis_inc      = mis_inc + IW'(1);
                                ev_valid     = 1'b1;
                                ev_rec.tid   = slots[i].tid;
                                ev_rec.seq   = slots[i].seq;
                                ev_rec.bound = slots[i].seq;
                                ev_rec.tgt   = slots[i].tgt;
                                ev_rec.taken = taken[i];
                                stop         = 1'b1;
                            end
                            SC_MISS_DEFER: begin
                                res_inc = res_inc + IW'(1);
                                mis_inc = mis_inc + IW'(1);
                                pend_d[slots[i].tid]       = 1'b1;
                                prec_d[slots[i].tid].tid   = slots[i].tid;
                                prec_d[slots[i].tid].seq   = slots[i].seq;
                                prec_d[slots[i].tid].bound = slots[i].seq + SEQ_W'(1);
                                prec_d[slots[i].tid].tgt   = slots[i].tgt;
                                prec_d[slots[i].tid].taken = taken[i];
                            end
                            default: begin
                            end
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bv_state.sv
`timescale 1ns/1ps
module bv_state
    import bv_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int IW    = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ev_valid,
    input  redir_t             ev_rec,
    input  logic      [IW-1:0] res_inc,
    input  logic      [IW-1:0] mis_inc,
    input  logic      [NT-1:0] pend_d,
    input  redir_t    [NT-1:0] prec_d,
    output logic               rv_q,
    output redir_t             rec_q,
    output logic [CNT_W-1:0]   res_q,
    output logic [CNT_W-1:0]   mis_q,
    output logic      [NT-1:0] pend_q,
    output redir_t    [NT-1:0] prec_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rv_q   <= 1'b0;
            rec_q  <= '0;
            res_q  <= '0;
            mis_q  <= '0;
            pend_q <= '0;
            prec_q <= '0;
        end else begin
            rv_q   <= ev_valid;
            rec_q  <= ev_valid ? ev_rec : '0;
            res_q  <= res_q + CNT_W'(res_inc);
            mis_q  <= mis_q + CNT_W'(mis_inc);
            pend_q <= pend_d;
            prec_q <= prec_d;
        end
    end
endmodule

// File: rtl/bv_top.sv
`timescale 1ns/1ps
module bv_top
    import bv_pkg::*;
#(
    parameter int W          = 4,
    parameter bit DELAY_SLOT = 1'b0,
    parameter int CNT_W      = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [W-1:0]                in_valid,
    input  logic [W-1:0][PC_W-1:0]      in_pc,
    input  logic [W-1:0][PC_W-1:0]      in_pred_npc,
    input  logic [W-1:0][PC_W-1:0]      in_tgt,
    input  logic [W-1:0]                in_ctrl,
    input  logic [W-1:0]                in_direct,
    input  logic [W-1:0]                in_uncond,
    input  logic [W-1:0]                in_pred_taken,
    input  logic [W-1:0]                in_cond_ds,
    input  logic [W-1:0]                in_no_src,
    input  logic [W-1:0][SEQ_W-1:0]     in_seq,
    input  logic [W-1:0][TID_W-1:0]     in_tid,
    output logic [W-1:0]                fwd_o,
    output logic [W-1:0]                kill_o,
    output logic [W-1:0]                ready_o,
    output logic                        stop_o,
    output logic                        fatal_o,
    output logic                        redir_valid_o,
    output logic                        redir_mispred_o,
    output logic                        redir_pred_wrong_o,
    output logic                        redir_squash_o,
    output logic [TID_W-1:0]            redir_tid_o,
    output logic [SEQ_W-1:0]            redir_seq_o,
    output logic [SEQ_W-1:0]            redir_bound_o,
    output logic [PC_W-1:0]             redir_npc_o,
    output logic [PC_W-1:0]             redir_nnpc_o,
    output logic                        redir_taken_o,
    output logic [CNT_W-1:0]            resolved_cnt_o,
    output logic [CNT_W-1:0]            mispred_cnt_o
);
    localparam int IW = $clog2(W + 1);

    slot_t     [W-1:0]  slots;
    slot_cls_e [W-1:0]  cls;
    logic      [W-1:0]  taken;
    logic      [NT-1:0] pend_q;
    logic      [NT-1:0] pend_d;
    redir_t    [NT-1:0] prec_q;
    redir_t    [NT-1:0] prec_d;
    logic      [IW-1:0] res_inc;
    logic      [IW-1:0] mis_inc;
    logic               ev_valid;
    redir_t             ev_rec;
    logic               rv_q;
    redir_t             rec_q;

    for (genvar g = 0; g < W; g++) begin : g_slot
        assign slots[g].valid      = in_valid[g];
        assign slots[g].pc         = in_pc[g];
        assign slots[g].pred_npc   = in_pred_npc[g];
        assign slots[g].tgt        = in_tgt[g];
        assign slots[g].ctrl       = in_ctrl[g];
        assign slots[g].direct     = in_direct[g];
        assign slots[g].uncond     = in_uncond[g];
        assign slots[g].pred_taken = in_pred_taken[g];
        assign slots[g].cond_ds    = in_cond_ds[g];
        assign slots[g].seq        = in_seq[g];
        assign slots[g].tid        = in_tid[g];

        bv_slot_class #(.DELAY_SLOT(DELAY_SLOT)) u_cls (
            .s     (slots[g]),
            .cls   (cls[g]),
            .taken (taken[g])
        );
    end

    bv_scan #(.W(W), .IW(IW)) u_scan (
        .slots    (slots),
        .cls      (cls),
        .taken    (taken),
        .pend_q   (pend_q),
        .prec_q   (prec_q),
        .fwd      (fwd_o),
        .kill     (kill_o),
        .stop     (stop_o),
        .fatal    (fatal_o),
        .res_inc  (res_inc),
        .mis_inc  (mis_inc),
        .ev_valid (ev_valid),
        .ev_rec   (ev_rec),
        .pend_d   (pend_d),
        .prec_d   (prec_d)
    );

    bv_state #(.CNT_W(CNT_W), .IW(IW)) u_state (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (ev_valid),
        .ev_rec   (ev_rec),
        .res_inc  (res_inc),
        .mis_inc  (mis_inc),
        .pend_d   (pend_d),
        .prec_d   (prec_d),
        .rv_q     (rv_q),
        .rec_q    (rec_q),
        .res_q    (resolved_cnt_o),
        .mis_q    (mispred_cnt_o),
        .pend_q   (pend_q),
        .prec_q   (prec_q)
    );

    assign ready_o            = in_valid & in_no_src;
    assign redir_valid_o      = rv_q;
    assign redir_mispred_o    = rv_q;
    assign redir_pred_wrong_o = rv_q;
    assign redir_squash_o     = rv_q;
    assign redir_tid_o        = rec_q.tid;
    assign redir_seq_o        = rec_q.seq;
    assign redir_bound_o      = rec_q.bound;
    assign redir_npc_o        = rec_q.tgt;
    assign redir_nnpc_o       = fallthru(rec_q.tgt);
    assign redir_taken_o      = rec_q.taken;
endmodule

// File: rtl/bv_checks.sv
`timescale 1ns/1ps
module bv_checks
    import bv_pkg::*;
#(
    parameter int W          = 4,
    parameter bit DELAY_SLOT = 1'b0,
    parameter int CNT_W      = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [W-1:0]       fwd_o,
    input logic [W-1:0]       kill_o,
    input logic               stop_o,
    input logic               fatal_o,
    input logic               redir_valid_o,
    input logic [SEQ_W-1:0]   redir_seq_o,
    input logic [SEQ_W-1:0]   redir_bound_o,
    input logic [CNT_W-1:0]   resolved_cnt_o,
    input logic [CNT_W-1:0]   mispred_cnt_o
);
    p_redir_after_stop_r3: assert property (@(posedge clk) disable iff (rst)
        redir_valid_o |-> $past(stop_o));

    p_kill_needs_stop_r5: assert property (@(posedge clk) disable iff (rst)
        !stop_o |-> (kill_o == '0));

    p_fwd_kill_apart_r12: assert property (@(posedge clk) disable iff (rst)
        (fwd_o & kill_o) == '0);

    p_fatal_no_redir_r9: assert property (@(posedge clk) disable iff (rst)
        fatal_o |=> !redir_valid_o);

    p_bound_r7: assert property (@(posedge clk) disable iff (rst)
        redir_valid_o |-> (redir_bound_o == redir_seq_o ||
                           (DELAY_SLOT && redir_bound_o == SEQ_W'(redir_seq_o + SEQ_W'(1)))));

    p_mis_le_res_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (CNT_W'(mispred_cnt_o - $past(mispred_cnt_o)) <=
                         CNT_W'(resolved_cnt_o - $past(resolved_cnt_o))));
endmodule

bind bv_top bv_checks #(.W(W), .DELAY_SLOT(DELAY_SLOT), .CNT_W(CNT_W)) u_checks (
    .clk            (clk),
    .rst            (rst),
    .fwd_o          (fwd_o),
    .kill_o         (kill_o),
    .stop_o         (stop_o),
    .fatal_o        (fatal_o),
    .redir_valid_o  (redir_valid_o),
    .redir_seq_o    (redir_seq_o),
    .redir_bound_o  (redir_bound_o),
    .resolved_cnt_o (resolved_cnt_o),
    .mispred_cnt_o  (mispred_cnt_o)
);

// File: tb/tb_bv_top.sv
`timescale 1ns/1ps
module tb_bv_top;
    import bv_pkg::*;
    localparam int W = 4;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [W-1:0]            v, ctl, dir, unc, pt, cds, nos;
    logic [W-1:0][PC_W-1:0]  pc, pnpc, tgt;
    logic [W-1:0][SEQ_W-1:0] sq;
    logic [W-1:0][TID_W-1:0] td;

    logic [W-1:0] o_fwd [2], o_kill [2], o_rdy [2];
    logic o_stop [2], o_fatal [2], o_rv [2], o_mf [2], o_pw [2], o_sf [2], o_tk [2];
    logic [TID_W-1:0] o_tid [2];
    logic [SEQ_W-1:0] o_seq [2], o_bnd [2];
    logic [PC_W-1:0]  o_npc [2], o_nnpc [2];
    logic [CW-1:0]    o_res [2], o_mis [2];

    bv_top #(.W(W), .DELAY_SLOT(1'b0), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .in_valid(v), .in_pc(pc), .in_pred_npc(pnpc), .in_tgt(tgt),
        .in_ctrl(ctl), .in_direct(dir), .in_uncond(unc), .in_pred_taken(pt),
        .in_cond_ds(cds), .in_no_src(nos), .in_seq(sq), .in_tid(td),
        .fwd_o(o_fwd[0]), .kill_o(o_kill[0]), .ready_o(o_rdy[0]), .stop_o(o_stop[0]),
        .fatal_o(o_fatal[0]), .redir_valid_o(o_rv[0]), .redir_mispred_o(o_mf[0]),
        .redir_pred_wrong_o(o_pw[0]), .redir_squash_o(o_sf[0]), .redir_tid_o(o_tid[0]),
        .redir_seq_o(o_seq[0]), .redir_bound_o(o_bnd[0]), .redir_npc_o(o_npc[0]),
        .redir_nnpc_o(o_nnpc[0]), .redir_taken_o(o_tk[0]),
        .resolved_cnt_o(o_res[0]), .mispred_cnt_o(o_mis[0]));

    bv_top #(.W(W), .DELAY_SLOT(1'b1), .CNT_W(CW)) dut_ds (
        .clk(clk), .rst(rst), .in_valid(v), .in_pc(pc), .in_pred_npc(pnpc), .in_tgt(tgt),
        .in_ctrl(ctl), .in_direct(dir), .in_uncond(unc), .in_pred_taken(pt),
        .in_cond_ds(cds), .in_no_src(nos), .in_seq(sq), .in_tid(td),
        .fwd_o(o_fwd[1]), .kill_o(o_kill[1]), .ready_o(o_rdy[1]), .stop_o(o_stop[1]),
        .fatal_o(o_fatal[1]), .redir_valid_o(o_rv[1]), .redir_mispred_o(o_mf[1]),
        .redir_pred_wrong_o(o_pw[1]), .redir_squash_o(o_sf[1]), .redir_tid_o(o_tid[1]),
        .redir_seq_o(o_seq[1]), .redir_bound_o(o_bnd[1]), .redir_npc_o(o_npc[1]),
        .redir_nnpc_o(o_nnpc[1]), .redir_taken_o(o_tk[1]),
        .resolved_cnt_o(o_res[1]), .mispred_cnt_o(o_mis[1]));

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input int m, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s mode=%0d actual=%0h expected=%0h t=%0t", req, m, act, exp, $time);
        end
    endtask

    // reference model state, per mode
    int unsigned m_res [2], m_mis [2];
    bit          m_pend [2][NT];
    int unsigned mp_seq [2][NT];
    longint      mp_tgt [2][NT];
    bit          mp_tk  [2][NT];
    bit          e_rv [2], e_tk [2];
    int unsigned e_tid [2], e_seq [2], e_bnd [2];
    longint      e_tgt [2];

    task automatic model_reset();
        for (int m = 0; m < 2; m++) begin
            m_res[m] = 0; m_mis[m] = 0; e_rv[m] = 0;
            e_tid[m] = 0; e_seq[m] = 0; e_bnd[m] = 0; e_tgt[m] = 0; e_tk[m] = 0;
            for (int t = 0; t < NT; t++) m_pend[m][t] = 0;
        end
    endtask

    task automatic check_regs();
        for (int m = 0; m < 2; m++) begin
            chk("R3 redirect valid", m, o_rv[m], e_rv[m]);
            chk("R3 flags", m, {o_mf[m], o_pw[m], o_sf[m]}, e_rv[m] ? 7 : 0);
            chk("R1 resolved count", m, o_res[m], m_res[m] & 16'hffff);
            chk("R2 mispredict count", m, o_mis[m], m_mis[m] & 16'hffff);
            if (e_rv[m]) begin
                chk("R3 tid", m, o_tid[m], e_tid[m]);
                chk("R3 seq", m, o_seq[m], e_seq[m]);
                chk(m ? "R7 bound" : "R5 bound", m, o_bnd[m], e_bnd[m]);
                chk("R3 npc", m, o_npc[m], e_tgt[m]);
                chk("R3 nnpc", m, o_nnpc[m], (e_tgt[m] + 4) & 32'hffffffff);
                chk("R4 taken", m, o_tk[m], e_tk[m]);
            end
        end
    endtask

    // evaluate one group: compare combinational outputs, advance model
    task automatic step();
        for (int m = 0; m < 2; m++) begin
            logic [W-1:0] xf = '0, xk = '0;
            bit halted = 0, sq_on = 0, xfatal = 0, nrv = 0;
            int unsigned st = 0, sb = 0;
            for (int i = 0; i < W; i++) begin
                int t;
                if (!v[i]) continue;
                t = td[i];
                if (halted) begin
                    if (sq_on && t == st && sq[i] > sb) xk[i] = 1;   // R5 / R12
                    continue;
                end
                xf[i] = 1;
                if (m_pend[m][t]) begin                               // R7, R8
                    m_pend[m][t] = 0;
                    nrv = 1; e_tid[m] = t; e_seq[m] = mp_seq[m][t];
                    e_bnd[m] = (mp_seq[m][t] + 1) & 16'hffff;
                    e_tgt[m] = mp_tgt[m][t]; e_tk[m] = mp_tk[m][t];
                    halted = 1; sq_on = 1; st = t; sb = e_bnd[m];
                    continue;
                end
                if (pt[i] && !ctl[i]) begin                            // R9
                    xfatal = 1; halted = 1;
                    continue;
                end
                if (ctl[i] && dir[i] && unc[i]) begin                  // R1
                    m_res[m]++;
                    if (tgt[i] != pnpc[i]) begin                       // R2
                        bit tk = (pnpc[i] != pc[i] + 32'd4);           // R4
                        m_mis[m]++;
                        if (m == 0 || (pt[i] && cds[i])) begin         // R5, R6
                            nrv = 1; e_tid[m] = t; e_seq[m] = sq[i]; e_bnd[m] = sq[i];
                            e_tgt[m] = tgt[i]; e_tk[m] = tk;
                            halted = 1; sq_on = 1; st = t; sb = sq[i];
                        end else begin                                 // R7
                            m_pend[m][t] = 1; mp_seq[m][t] = sq[i];
                            mp_tgt[m][t] = tgt[i]; mp_tk[m][t] = tk;
                        end
                    end
                end
            end
            chk("R12 forwarded slots", m, o_fwd[m], xf);
            chk("R5 killed slots", m, o_kill[m], xk);
            chk("R5 stop", m, o_stop[m], halted);
            chk("R9 fatal", m, o_fatal[m], xfatal);
            chk("R10 ready", m, o_rdy[m], v & nos);
            e_rv[m] = nrv;
        end
    endtask

    task automatic run_cycle();
        #1;
        step();
        @(negedge clk);
        check_regs();
    endtask

    task automatic clear();
        v = '0; ctl = '0; dir = '0; unc = '0; pt = '0; cds = '0; nos = '0;
        pc = '0; pnpc = '0; tgt = '0; sq = '0; td = '0;
    endtask

    task automatic put(input int i, input int t, input int s, input logic [31:0] p,
                       input logic [31:0] pn, input logic [31:0] tg,
                       input bit br, input bit ptk, input bit cd);
        v[i] = 1; td[i] = TID_W'(t); sq[i] = SEQ_W'(s); pc[i] = p; pnpc[i] = pn; tgt[i] = tg;
        ctl[i] = br; dir[i] = br; unc[i] = br; pt[i] = ptk; cds[i] = cd; nos[i] = 0;
    endtask

    int unsigned tseq [NT];

    initial begin
        clear();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_regs();                                     // R11 reset state

        // R5 / R7: mispredict mid-group, not taken
        clear();
        put(0, 0, 10, 32'h100, 32'h104, 32'h0, 0, 0, 0);
        put(1, 0, 11, 32'h104, 32'h108, 32'h200, 1, 0, 0);
        put(2, 0, 12, 32'h108, 32'h10c, 32'h0, 0, 0, 0);
        put(3, 1, 5,  32'h400, 32'h404, 32'h0, 0, 0, 0);
        nos[0] = 1;
        run_cycle();
        // R7 across cycles: deferred branch in last slot, predicted taken
        clear();
        put(0, 0, 13, 32'h200, 32'h204, 32'h0, 0, 0, 0);
        put(3, 1, 6,  32'h500, 32'h800, 32'h900, 1, 1, 0);
        run_cycle();
        clear();
        put(0, 1, 7, 32'h504, 32'h508, 32'h0, 0, 0, 0);
        put(1, 1, 8, 32'h508, 32'h50c, 32'h0, 0, 0, 0);
        put(2, 0, 14, 32'h204, 32'h208, 32'h0, 0, 0, 0);
        run_cycle();
        // R6: predicted taken, conditional delay slot
        clear();
        put(0, 0, 20, 32'h300, 32'h340, 32'h380, 1, 1, 1);
        put(1, 0, 21, 32'h304, 32'h308, 32'h0, 0, 0, 0);
        run_cycle();
        // R9: predicted taken non-control
        clear();
        put(0, 0, 30, 32'h600, 32'h700, 32'h0, 0, 1, 0);
        put(1, 0, 31, 32'h604, 32'h608, 32'h0, 0, 0, 0);
        run_cycle();
        // R8: delay-slot instruction is itself a mispredicting branch
        clear();
        put(0, 0, 40, 32'h700, 32'h704, 32'h900, 1, 0, 0);
        put(1, 0, 41, 32'h704, 32'h708, 32'ha00, 1, 0, 0);
        put(2, 0, 42, 32'h708, 32'h70c, 32'h0, 0, 0, 0);
        run_cycle();
        // R1: correctly predicted branches only count as resolved
        clear();
        put(0, 1, 50, 32'h800, 32'h880, 32'h880, 1, 1, 0);
        put(1, 1, 51, 32'h880, 32'h884, 32'h884, 1, 0, 0);
        run_cycle();
        clear();
        run_cycle();

        for (int t = 0; t < NT; t++) tseq[t] = 100;
        for (int c = 0; c < 4000; c++) begin
            clear();
            for (int i = 0; i < W; i++) begin
                int t = $urandom_range(0, NT - 1);
                bit br = ($urandom_range(0, 2) == 0);
                logic [31:0] p = {$urandom_range(0, 255), 2'b00};
                logic [31:0] pn = ($urandom_range(0, 1) == 1) ? p + 32'd4 : {$urandom_range(0, 255), 2'b00};
                logic [31:0] tg = ($urandom_range(0, 1) == 1) ? pn : {$urandom_range(0, 255), 2'b00};
                bit ptk = br ? bit'($urandom_range(0, 1)) : ($urandom_range(0, 39) == 0);
                put(i, t, int'(tseq[t]), p, pn, tg, br, ptk, bit'($urandom_range(0, 1)));
                dir[i] = br & ($urandom_range(0, 3) != 0);
                unc[i] = br & ($urandom_range(0, 3) != 0);
                nos[i] = bit'($urandom_range(0, 1));
                v[i] = ($urandom_range(0, 4) != 0);
                tseq[t]++;
            end
            run_cycle();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule